// File: doc/BRIEF.md
# Disk Record Write Capture

This block sits behind a write-path data separator of a disk emulator that keeps its disk image in RAM. It receives the recovered bit stream one bit at a time, with a strobe for each bit, and turns it into the records of a sector. While it has no alignment it throws away zero bits. The first one bit it sees is the sync mark. The bits after it are packed into words, most significant bit first. The record type from the rotation logic, sampled at the moment of sync, selects a header, label or data record. That choice sets how many words the record holds and where they land inside the sector's slot in RAM.

Each data word goes out on a RAM write port. Its address is the current cylinder register, the host's head line, the current sector number and a word offset inside the sector. The block keeps an XOR checksum over the data words, starting from a seed. It compares that checksum with the word that follows the last data word. A mismatch sets a sticky error flag, because the host has no way to be told. After a header or label record the block goes back to hunting for sync, so several records can be written in one write-gate session. After a data record the sector is complete and further bits are ignored. When write gate drops, the block returns to idle at once.

Top module: `disk_rec_capture`

## Requirements
- R1: After reset, ram_we_o, rec_done_o and csum_err_o are all 0.
- R2: While hunting, zero bits are dropped and cause no write. The first one bit (bit_valid_i=1, bit_i=1) is the sync mark. The next 16 strobed bits form a word, the first received bit landing in bit 15.
- R3: The record type rec_type_i is sampled in the cycle the sync bit is taken. Code 0 selects a header of 2 words, code 1 a label of 8 words, and code 2 or 3 a data record of DAT_WORDS words. Later changes to rec_type_i have no effect on that record.
- R4: Each data word is written once with ram_addr_o = {cyl_i, head_i, sector_i, offset}. The offset is the word index plus a base of 0 for the header, 2 for the label and 10 for data.
- R5: The word after the last data word is the checksum and is not written. csum_err_o is set when that word differs from 0x0151 XOR all data words of the record, and stays unchanged when it matches.
- R6: csum_err_o stays set until err_clr_i is asserted. A clear then returns it to 0.
- R7: rec_done_o pulses for one cycle for each completed checksum word.
- R8: After the checksum of a header or label, sync is dropped. Zero bits of the gap are discarded, and the next one bit starts the following record in the same write-gate session.
- R9: After the checksum of a data record, all further bits, ones included, cause no write, no done pulse and no sync until write gate drops.
- R10: Dropping wgate_i returns the block to hunting at any point. Words of a cut-off record that were already written remain, and no done pulse or error results. A new session hunts for sync afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wgate_i | input | 1 | Write gate from the host; low forces idle |
| bit_valid_i | input | 1 | Strobe: one recovered bit this cycle |
| bit_i | input | 1 | Recovered bit value |
| rec_type_i | input | 2 | Record type from the rotation logic (0 header, 1 label, 2/3 data) |
| cyl_i | input | CYL_W | Current cylinder register |
| head_i | input | HEAD_W | Head select from the host |
| sector_i | input | SEC_W | Current sector number |
| err_clr_i | input | 1 | Clears the sticky checksum error |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | CYL_W+HEAD_W+SEC_W+OFS_W | RAM word address |
| ram_wdata_o | output | WORD_W | RAM write data |
| rec_done_o | output | 1 | One-cycle pulse at the end of each record |
| csum_err_o | output | 1 | Sticky checksum mismatch flag |

## Verification
The bench narrows the cylinder and sector fields to 2 bits each and shortens the data record to 16 words. The header and label keep 2 and 8 words. With that configuration it can walk every cylinder, head and sector code in full sessions of header, label and data. Every RAM address the block can produce for those sessions is then written and compared. The short data record leaves room for corrupted checksums, error clears, mid-record write-gate drops and trailing bits after the data record, all within one run.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_BODY = 2'd1,
    ST_END  = 2'd2
  } frm_state_e;

  localparam logic [1:0] RT_HDR = 2'd0;
  localparam logic [1:0] RT_LBL = 2'd1;
endpackage

// File: rtl/drc_deser.sv
module drc_deser #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic              halt_i,
  input  logic              resync_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic              sync_hit_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              synced_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic              wv_q;

  assign sync_hit_o   = gate_i && !halt_i && !synced_q && bit_valid_i && bit_i;
  assign word_valid_o = wv_q;
  assign word_o       = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      wv_q     <= 1'b0;
    end else if (!gate_i || resync_i) begin
      synced_q <= 1'b0;
      cnt_q    <= '0;
      wv_q     <= 1'b0;
    end else begin
      wv_q <= 1'b0;
      if (sync_hit_o) begin
        synced_q <= 1'b1;
        cnt_q    <= '0;
      end else if (synced_q && bit_valid_i) begin
        sh_q <= {sh_q[WORD_W-2:0], bit_i};
        if (cnt_q == CNT_W'(WORD_W-1)) begin
          cnt_q <= '0;
          wv_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_WORD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o); // R2
  AST_HUNT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_q |=> !word_valid_o); // R2
endmodule

// File: rtl/drc_framer.sv
module drc_framer
  import drc_pkg::*;
#(
  parameter int              WORD_W    = 16,
  parameter int              HDR_WORDS = 2,
  parameter int              LBL_WORDS = 8,
  parameter int              DAT_WORDS = 256,
  parameter logic [WORD_W-1:0] CSUM_SEED = 16'h0151,
  parameter int              OFS_W     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_i,
  input  logic              sync_hit_i,
  input  logic [1:0]        rec_type_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              err_clr_i,
  output logic              wr_en_o,
  output logic [OFS_W-1:0]  wr_ofs_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              resync_o,
  output logic              halt_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int MAXL  = (DAT_WORDS > LBL_WORDS) ?
                         ((DAT_WORDS > HDR_WORDS) ? DAT_WORDS : HDR_WORDS) :
                         ((LBL_WORDS > HDR_WORDS) ? LBL_WORDS : HDR_WORDS);
  localparam int IDX_W = $clog2(MAXL + 1);

  frm_state_e        st_q;
  logic [IDX_W-1:0]  idx_q, len_q, len_d;
  logic [OFS_W-1:0]  base_q, base_d;
  logic [WORD_W-1:0] csum_q;
  logic              is_dat_q, is_dat_d;
  logic              done_q, err_q;
  logic              in_csum;
  logic              csum_bad;

  always_comb begin
    case (rec_type_i)
      RT_HDR: begin
        len_d = IDX_W'(HDR_WORDS); base_d = '0; is_dat_d = 1'b0;
      end
      RT_LBL: begin
        len_d = IDX_W'(LBL_WORDS); base_d = OFS_W'(HDR_WORDS); is_dat_d = 1'b0;
      end
      default: begin
        len_d = IDX_W'(DAT_WORDS); base_d = OFS_W'(HDR_WORDS + LBL_WORDS); is_dat_d = 1'b1;
      end
    endcase
  end

  assign in_csum   = (idx_q == len_q);
  assign wr_en_o   = gate_i && (st_q == ST_BODY) && word_valid_i && !in_csum;
  assign wr_ofs_o  = base_q + OFS_W'(idx_q);
  assign wr_data_o = word_i;
  assign resync_o  = (st_q == ST_BODY) && word_valid_i && in_csum;
  assign halt_o    = (st_q == ST_END);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign csum_bad  = gate_i && resync_o && (word_i != csum_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_HUNT;
      idx_q    <= '0;
      len_q    <= '0;
      base_q   <= '0;
      csum_q   <= '0;
      is_dat_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!gate_i) begin
        st_q <= ST_HUNT;
      end else begin
        case (st_q)
          ST_HUNT: if (sync_hit_i) begin
            st_q     <= ST_BODY;
            idx_q    <= '0;
            len_q    <= len_d;
            base_q   <= base_d;
            is_dat_q <= is_dat_d;
            csum_q   <= CSUM_SEED;
          end
          ST_BODY: if (word_valid_i) begin
            if (!in_csum) begin
              idx_q  <= idx_q + 1'b1;
              csum_q <= csum_q ^ word_i;
            end else begin
              st_q   <= is_dat_q ? ST_END : ST_HUNT;
              done_q <= 1'b1;
            end
          end
          default: st_q <= ST_END;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (csum_bad)  err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BODY) |-> (idx_q <= len_q)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o); // R6
  AST_NO_SYNC_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !sync_hit_i); // R9
endmodule

// File: rtl/drc_addr.sv
module drc_addr #(
  parameter int WORD_W = 16,
  parameter int CYL_W  = 8,
  parameter int HEAD_W = 1,
  parameter int SEC_W  = 4,
  parameter int OFS_W  = 9,
  parameter int ADDR_W = CYL_W + HEAD_W + SEC_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [SEC_W-1:0]  sector_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= wr_en_i;
      if (wr_en_i) begin
        addr_o  <= {cyl_i, head_i, sector_i, ofs_i};
        wdata_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/disk_rec_capture.sv
module disk_rec_capture #(
  parameter int              WORD_W    = 16,
  parameter int              HDR_WORDS = 2,
  parameter int              LBL_WORDS = 8,
  parameter int              DAT_WORDS = 256,
  parameter logic [WORD_W-1:0] CSUM_SEED = 16'h0151,
  parameter int              CYL_W     = 8,
  parameter int              HEAD_W    = 1,
  parameter int              SEC_W     = 4,
  localparam int             OFS_W     = $clog2(HDR_WORDS + LBL_WORDS + DAT_WORDS),
  localparam int             ADDR_W    = CYL_W + HEAD_W + SEC_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wgate_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic [1:0]        rec_type_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [SEC_W-1:0]  sector_i,
  input  logic              err_clr_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_wdata_o,
  output logic              rec_done_o,
  output logic              csum_err_o
);
  logic              sync_hit, word_valid, resync, halt, wr_en;
  logic [WORD_W-1:0] word, wr_data;
  logic [OFS_W-1:0]  wr_ofs;

  drc_deser #(.WORD_W(WORD_W)) u_deser (
    .clk_i, .rst_ni,
    .gate_i       (wgate_i),
    .halt_i       (halt),
    .resync_i     (resync),
    .bit_valid_i,
    .bit_i,
    .sync_hit_o   (sync_hit),
    .word_valid_o (word_valid),
    .word_o       (word)
  );

  drc_framer #(
    .WORD_W(WORD_W), .HDR_WORDS(HDR_WORDS), .LBL_WORDS(LBL_WORDS),
    .DAT_WORDS(DAT_WORDS), .CSUM_SEED(CSUM_SEED), .OFS_W(OFS_W)
  ) u_framer (
    .clk_i, .rst_ni,
    .gate_i       (wgate_i),
    .sync_hit_i   (sync_hit),
    .rec_type_i,
    .word_valid_i (word_valid),
    .word_i       (word),
    .err_clr_i,
    .wr_en_o      (wr_en),
    .wr_ofs_o     (wr_ofs),
    .wr_data_o    (wr_data),
    .resync_o     (resync),
    .halt_o       (halt),
    .done_o       (rec_done_o),
    .err_o        (csum_err_o)
  );

  drc_addr #(
    .WORD_W(WORD_W), .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W),
    .OFS_W(OFS_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .clk_i, .rst_ni,
    .wr_en_i  (wr_en),
    .ofs_i    (wr_ofs),
    .data_i   (wr_data),
    .cyl_i,
    .head_i,
    .sector_i,
    .we_o     (ram_we_o),
    .addr_o   (ram_addr_o),
    .wdata_o  (ram_wdata_o)
  );

  AST_WE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> $past(wgate_i)); // R10
  AST_CSUM_NOT_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_done_o |-> !ram_we_o); // R5
endmodule

// File: tb/disk_rec_capture_test.sv
module disk_rec_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int CYL_W = 2, HEAD_W = 1, SEC_W = 2, DATW = 16;
  localparam int OFS_W  = $clog2(2 + 8 + DATW);
  localparam int ADDR_W = CYL_W + HEAD_W + SEC_W + OFS_W;
  localparam logic [15:0] SEED = 16'h0151;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wgate = 1'b0, bit_valid = 1'b0, bit_v = 1'b0, err_clr = 1'b0;
  logic [1:0] rec_type = 2'd0;
  logic [CYL_W-1:0] cyl = '0;
  logic [HEAD_W-1:0] head = '0;
  logic [SEC_W-1:0] sector = '0;
  logic ram_we, rec_done, csum_err;
  logic [ADDR_W-1:0] ram_addr;
  logic [15:0] ram_wdata;

  int n_chk = 0, n_fail = 0, n_wr = 0, n_done = 0;
  logic exp_err = 1'b0;
  logic [ADDR_W+15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  disk_rec_capture #(.DAT_WORDS(DATW), .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wgate_i(wgate), .bit_valid_i(bit_valid), .bit_i(bit_v),
    .rec_type_i(rec_type), .cyl_i(cyl), .head_i(head), .sector_i(sector), .err_clr_i(err_clr),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .rec_done_o(rec_done), .csum_err_o(csum_err)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rec_done) n_done++;
    if (rst_n && ram_we) begin
      n_wr++;
      if (exp_q.size() == 0) chk(1'b0, "R9/R2 unexpected write", 64'(ram_addr), 64'hx);
      else begin
        logic [ADDR_W+15:0] e;
        e = exp_q.pop_front();
        chk({ram_addr, ram_wdata} == e, "R4 write addr/data", 64'({ram_addr, ram_wdata}), 64'(e));
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_v = b;
    @(negedge clk); bit_valid = 1'b0; bit_v = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  function automatic logic [15:0] pat(input int s, input int r, input int i);
    case (s % 4)
      1: return 16'hFFFF;
      2: return (i % 2 == 0) ? 16'h0000 : 16'(16'h8000 >> (i % 16));
      default: return 16'((s * 37 + r * 101 + i * 16'h1357) ^ (16'h8001 << (i % 15)));
    endcase
  endfunction

  // rt: 0 header, 1 label, 2 data; base offsets 0/2/10
  task automatic send_record(input int rt, input int s, input logic bad, input int nwords_cut);
    int len, base, nw;
    logic [15:0] cs, w;
    len  = (rt == 0) ? 2 : (rt == 1) ? 8 : DATW;
    base = (rt == 0) ? 0 : (rt == 1) ? 2 : 10;
    nw   = (nwords_cut >= 0) ? nwords_cut : len;
    cs   = SEED;
    rec_type = 2'(rt);
    send_bit(1'b1);
    rec_type = 2'd3 - 2'(rt);   // R3: changes after sync must not matter
    for (int i = 0; i < nw; i++) begin
      w = pat(s, rt, i);
      cs ^= w;
      exp_q.push_back({cyl, head, sector, OFS_W'(base + i), w});
      send_word(w);
    end
    if (nwords_cut < 0) begin
      send_word(bad ? (cs ^ 16'h0040) : cs);
      if (bad) exp_err = 1'b1;
    end
  endtask

  task automatic session(input int c, input int h, input int sc, input logic bad_lbl);
    int d0, w0, s;
    s = c * 8 + h * 4 + sc;
    cyl = CYL_W'(c); head = HEAD_W'(h); sector = SEC_W'(sc);
    @(negedge clk); wgate = 1'b1;
    d0 = n_done;
    w0 = n_wr;
    send_zeros(7 + s % 5);
    chk(n_wr == w0, "R2 leading zeros no write", 64'(n_wr), 64'(w0));
    send_record(0, s, 1'b0, -1);
    send_zeros(64);              // R8 gap, resync
    send_record(1, s, bad_lbl, -1);
    send_zeros(64);
    chk(csum_err == exp_err, "R5 label checksum", 64'(csum_err), 64'(exp_err));
    send_record(2, s, 1'b0, -1);
    send_zeros(5);
    chk(n_done == d0 + 3, "R7 done per record", 64'(n_done), 64'(d0 + 3));
    chk(exp_q.size() == 0, "R4/R3 all words written", 64'(exp_q.size()), 64'd0);
    w0 = n_wr;
    send_bit(1'b1);
    send_word(16'hA5C3);
    send_word(16'hFFFF);
    chk(n_wr == w0 && n_done == d0 + 3, "R9 bits after data ignored", 64'(n_wr), 64'(w0));
    chk(csum_err == exp_err, "R5 error state", 64'(csum_err), 64'(exp_err));
    @(negedge clk); wgate = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ram_we == 1'b0, "R1 we reset", 64'(ram_we), 64'd0);
    chk(rec_done == 1'b0, "R1 done reset", 64'(rec_done), 64'd0);
    chk(csum_err == 1'b0, "R1 err reset", 64'(csum_err), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int c = 0; c < 4; c++)
      for (int h = 0; h < 2; h++)
        for (int sc = 0; sc < 4; sc++) begin
          logic bad;
          bad = ((c * 8 + h * 4 + sc) % 7 == 3);
          session(c, h, sc, bad);
          if (exp_err) begin
            chk(csum_err == 1'b1, "R6 error held", 64'(csum_err), 64'd1);
            @(negedge clk); err_clr = 1'b1;
            @(negedge clk); err_clr = 1'b0;
            exp_err = 1'b0;
            @(negedge clk);
            chk(csum_err == 1'b0, "R6 error cleared", 64'(csum_err), 64'd0);
          end
        end

    // R10: write gate drop in mid record
    begin
      int d0;
      d0 = n_done;
      cyl = 2'd2; head = 1'b1; sector = 2'd1;
      @(negedge clk); wgate = 1'b1;
      send_zeros(3);
      send_record(1, 5, 1'b0, 3);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      @(negedge clk); wgate = 1'b0;
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R10 words before drop kept", 64'(exp_q.size()), 64'd0);
      chk(n_done == d0, "R10 no done on truncation", 64'(n_done), 64'(d0));
      chk(csum_err == 1'b0, "R10 no error on truncation", 64'(csum_err), 64'd0);
      session(1, 0, 3, 1'b0);
      chk(csum_err == 1'b0, "R10 clean session after drop", 64'(csum_err), 64'd0);
    end
    finish_run();
  end
endmodule